// File: doc/BRIEF.md
# MFM Write Encoder and Read Decoder

This block turns a stream of bytes into modified frequency modulation write pulses for a magnetic recording channel. It also decodes such a pulse train back into bytes. Every bit cell lasts `CELL_CLKS` system clocks and has two halves. The first half is the clock slot and the second half is the data slot. The encoder shifts each byte out most significant bit first. It places a pulse in the data slot for every one. It places a pulse in the clock slot only for a zero that follows another zero. To apply that rule it keeps one bit of history.

The decoder runs from its own fixed cell timer, started by the same enable. It rebuilds each bit from whether a pulse landed in the data half of the cell. Pulses in the clock half carry no data. They are only compared against the encoding rule, and a mismatch raises a one-cycle code error. In normal use the write line is looped to the read line, or the read line comes from a recovered pulse train that is already aligned to the cell grid.

Top module: `mfm_codec`

## Requirements
- R1: A cell whose bit is 1 carries exactly one write pulse, in its data slot. The data slot is the single clock cycle that follows the `CELL_CLKS/2`-th rising edge after the cell starts. A cell starts at each rising edge where `enable` is high and the phase count is 0. Such a cell never carries a clock-slot pulse.
- R2: A 0 cell whose previous bit was 1 carries no pulse in either slot.
- R3: A 0 cell whose previous bit was 0 carries exactly one pulse, in its clock slot. The clock slot is the single cycle that follows the first rising edge after the cell start.
- R4: The bit history resets to 1, so a 0 in the first cell after reset emits no pulse.
- R5: Bytes leave most significant bit first. The block holds one byte in a holding slot. `in_ready` is high only while that slot is empty and the current byte is in its last cell, or when no byte is in flight. `in_ready` drops in the cycle after a byte is accepted.
- R6: If no byte is waiting when a new byte is needed, the encoder emits 0 cells and `in_ready` stays high.
- R7: Write pulses last one cycle. No pulse appears in any other slot. While `enable` is low the write line stays low and the phase count is held at 0.
- R8: The decoder takes a bit from a read pulse seen in the data half of each cell. It packs the bits most significant first. It raises `out_valid` for one cycle at the close of every `DATA_W`-th cell after enable, and the first cell after enable is cell 0.
- R9: At each cell close the decoder raises `code_err` for one cycle if a clock-half pulse was seen but the rule of R2/R3 forbids one, or if no clock-half pulse was seen but the rule requires one. The decoder history also starts at 1 on enable.
- R10: During reset `in_ready` is 1, and `wr_pulse`, `out_valid` and `code_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs both cell timers; low holds them at phase 0 |
| in_valid | input | 1 | Byte offered to the encoder |
| in_ready | output | 1 | Encoder holding slot can take a byte |
| in_data | input | DATA_W | Byte to encode, most significant bit sent first |
| wr_pulse | output | 1 | One-cycle write pulse line |
| rd_pulse | input | 1 | Read pulse line into the decoder |
| out_valid | output | 1 | Decoded byte strobe |
| out_data | output | DATA_W | Decoded byte |
| code_err | output | 1 | Clock-slot pulse disagrees with the encoding rule |

## Verification
The bench builds the block with `CELL_CLKS` = 8 and `DATA_W` = 8. A cell is then eight clocks long, and every byte value from 0 to 255 can be streamed through the loopback in about sixteen thousand cycles. That sweep covers every pair of adjacent bits, inside bytes and across byte boundaries, and every slot of every cell is compared with an arithmetic model. Running past the last byte exercises the underrun zeros. A second pass after reset drives hand-placed read pulses to exercise each kind of code violation.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

  typedef enum logic [1:0] {
    SLOT_EDGE  = 2'd0,
    SLOT_CLOCK = 2'd1,
    SLOT_DATA  = 2'd2
  } mfm_slot_e;

  // Classify a phase count into the half of the cell it belongs to.
  function automatic mfm_slot_e mfm_slot(input int unsigned phase, input int unsigned half);
    if (phase == 0)         return SLOT_EDGE;
    else if (phase <= half) return SLOT_CLOCK;
    else                    return SLOT_DATA;
  endfunction

endpackage

// File: rtl/mfm_rst_sync.sv
module mfm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/mfm_cell_timer.sv
module mfm_cell_timer #(
  parameter int CELL_CLKS = 8,
  parameter int PH_W      = $clog2(CELL_CLKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [PH_W-1:0] ph,
  output logic            cell_start
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_CLKS - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    if (!en)                ph_d = '0;
    else if (ph_q == PH_LAST) ph_d = '0;
    else                    ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph         = ph_q;
  assign cell_start = en && (ph_q == '0);

  AST_PHASE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (ph_q == '0)); // R7

endmodule

// File: rtl/mfm_encoder.sv
module mfm_encoder #(
  parameter int DATA_W    = 8,
  parameter int CELL_CLKS = 8,
  parameter int PH_W      = $clog2(CELL_CLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PH_W-1:0]   ph,
  input  logic              cell_start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              wr_pulse
);

  localparam int              HALF    = CELL_CLKS / 2;
  localparam int              CNT_W   = $clog2(DATA_W + 1);
  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
  localparam logic [PH_W-1:0] PH_TWO  = PH_W'(2);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_vld_q, hold_vld_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              cur_q, cur_d;
  logic              prev_q, prev_d;
  logic              pulse_q, pulse_d;
  logic              accept;

  assign in_ready = !hold_vld_q && (left_q == '0);
  assign accept   = in_valid && in_ready;

  always_comb begin
    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    shift_d    = shift_q;
    left_d     = left_q;
    cur_d      = cur_q;
    prev_d     = prev_q;

    if (accept) begin
      hold_d     = in_data;
      hold_vld_d = 1'b1;
    end

    if (cell_start) begin
      prev_d = cur_q;
      if (left_q != '0) begin
        cur_d   = shift_q[DATA_W-1];
        shift_d = shift_q << 1;
        left_d  = left_q - CNT_W'(1);
      end else if (hold_vld_q) begin
        cur_d      = hold_q[DATA_W-1];
        shift_d    = hold_q << 1;
        left_d     = CNT_FULL;
        hold_vld_d = 1'b0;
      end else begin
        cur_d = 1'b0;
      end
    end

    pulse_d = en && (((ph == PH_ONE) && !cur_q && !prev_q) ||
                     ((ph == PH_HALF) && cur_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      shift_q    <= '0;
      left_q     <= '0;
      cur_q      <= 1'b1;
      prev_q     <= 1'b1;
      pulse_q    <= 1'b0;
    end else begin
      hold_q     <= hold_d;
      hold_vld_q <= hold_vld_d;
      shift_q    <= shift_d;
      left_q     <= left_d;
      cur_q      <= cur_d;
      prev_q     <= prev_d;
      pulse_q    <= pulse_d;
    end
  end

  assign wr_pulse = pulse_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R7

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !wr_pulse); // R7

  AST_ONE_HAS_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (ph == PH_TWO) && cur_q) |-> !wr_pulse); // R1

  AST_ACCEPT_FILLS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R5

endmodule

// File: rtl/mfm_decoder.sv
module mfm_decoder #(
  parameter int DATA_W    = 8,
  parameter int CELL_CLKS = 8,
  parameter int PH_W      = $clog2(CELL_CLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PH_W-1:0]   ph,
  input  logic              cell_start,
  input  logic              rd_pulse,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              code_err
);
  import mfm_pkg::*;

  localparam int               HALF     = CELL_CLKS / 2;
  localparam int               BIT_W    = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic              started_q, started_d;
  logic              seen_clk_q, seen_clk_d;
  logic              seen_dat_q, seen_dat_d;
  logic              prev_q, prev_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [BIT_W-1:0]  cnt_q, cnt_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              err_q, err_d;
  mfm_slot_e         slot;

  assign slot = mfm_slot(32'(ph), HALF);

  always_comb begin
    started_d  = started_q;
    seen_clk_d = seen_clk_q;
    seen_dat_d = seen_dat_q;
    prev_d     = prev_q;
    shift_d    = shift_q;
    cnt_d      = cnt_q;
    data_d     = data_q;
    valid_d    = 1'b0;
    err_d      = 1'b0;

    if (!en) begin
      started_d  = 1'b0;
      seen_clk_d = 1'b0;
      seen_dat_d = 1'b0;
      prev_d     = 1'b1;
      cnt_d      = '0;
    end else if (cell_start) begin
      started_d  = 1'b1;
      seen_clk_d = 1'b0;
      seen_dat_d = 1'b0;
      if (started_q) begin
        err_d   = seen_clk_q != (!seen_dat_q && !prev_q);
        prev_d  = seen_dat_q;
        shift_d = {shift_q[DATA_W-2:0], seen_dat_q};
        if (cnt_q == BIT_LAST) begin
          cnt_d   = '0;
          valid_d = 1'b1;
          data_d  = {shift_q[DATA_W-2:0], seen_dat_q};
        end else begin
          cnt_d = cnt_q + BIT_W'(1);
        end
      end
    end else if (rd_pulse) begin
      if (slot == SLOT_CLOCK) seen_clk_d = 1'b1;
      if (slot == SLOT_DATA)  seen_dat_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q  <= 1'b0;
      seen_clk_q <= 1'b0;
      seen_dat_q <= 1'b0;
      prev_q     <= 1'b1;
      shift_q    <= '0;
      cnt_q      <= '0;
      valid_q    <= 1'b0;
      data_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      started_q  <= started_d;
      seen_clk_q <= seen_clk_d;
      seen_dat_q <= seen_dat_d;
      prev_q     <= prev_d;
      shift_q    <= shift_d;
      cnt_q      <= cnt_d;
      valid_q    <= valid_d;
      data_q     <= data_d;
      err_q      <= err_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign code_err  = err_q;

  AST_BYTE_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R8

  AST_ERR_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (ph == PH_W'(1))); // R9

endmodule

// File: rtl/mfm_codec.sv
module mfm_codec #(
  parameter int CELL_CLKS = 500,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_pulse,
  input  logic              rd_pulse,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              code_err
);

  localparam int PH_W = $clog2(CELL_CLKS);

  logic            rst_n_s;
  logic [PH_W-1:0] enc_ph, dec_ph;
  logic            enc_start, dec_start;

  mfm_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  mfm_cell_timer #(.CELL_CLKS(CELL_CLKS), .PH_W(PH_W)) u_enc_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en         (enable),
    .ph         (enc_ph),
    .cell_start (enc_start)
  );

  mfm_cell_timer #(.CELL_CLKS(CELL_CLKS), .PH_W(PH_W)) u_dec_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en         (enable),
    .ph         (dec_ph),
    .cell_start (dec_start)
  );

  mfm_encoder #(.DATA_W(DATA_W), .CELL_CLKS(CELL_CLKS), .PH_W(PH_W)) u_encoder (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en         (enable),
    .ph         (enc_ph),
    .cell_start (enc_start),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .wr_pulse   (wr_pulse)
  );

  mfm_decoder #(.DATA_W(DATA_W), .CELL_CLKS(CELL_CLKS), .PH_W(PH_W)) u_decoder (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en         (enable),
    .ph         (dec_ph),
    .cell_start (dec_start),
    .rd_pulse   (rd_pulse),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .code_err   (code_err)
  );

endmodule

// File: tb/mfm_codec_bench.sv
`timescale 1ns/1ps
module mfm_codec_bench;

  localparam int CELL = 8;
  localparam int HALF = CELL / 2;
  localparam int DW   = 8;
  localparam int NBYTES = 256;
  localparam int NBITS  = NBYTES * DW;

  logic          clk;
  logic          rst_n;
  logic          enable;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          wr_pulse;
  logic          rd_pulse;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          code_err;

  int   n_chk;
  int   n_err;
  int   mode;      // 0 loopback stream, 1 injected read pulses
  logic mon_on;
  int   j;
  int   q;
  logic inj;
  int   cyc;
  logic done;

  assign rd_pulse = (mode == 1) ? inj : wr_pulse;

  mfm_codec #(.CELL_CLKS(CELL), .DATA_W(DW)) u_mfm_codec (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .wr_pulse  (wr_pulse),
    .rd_pulse  (rd_pulse),
    .out_valid (out_valid),
    .out_data  (out_data),
    .code_err  (code_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h (cell time %0d)", tag, got, exp, j);
    end
  endtask

  function automatic logic ebit(input int c);
    if (mode == 1 || c >= NBITS) return 1'b0;
    return 1'(((c / DW) >> (DW - 1 - (c % DW))) & 1);
  endfunction

  function automatic logic inj_clk(input int c);
    return (c == 1) || (c == 3) || (c == 4);
  endfunction

  function automatic logic inj_dat(input int c);
    return (c == 0) || (c >= 4 && c <= 7);
  endfunction

  always @(posedge clk) begin
    if (!mon_on) j = -1;
    else         j = j + 1;
  end

  always @(negedge clk) begin : monitor
    int   c;
    int   r;
    logic b;
    logic p;
    logic exp_p;
    logic exp_e;
    if (!mon_on) begin
      q   = 0;
      inj = 1'b0;
    end else if (j >= 0) begin
      c = j / CELL;
      r = j % CELL;
      b = ebit(c);
      p = (c == 0) ? 1'b1 : ebit(c - 1);
      exp_p = ((r == 1) && !b && !p) || ((r == HALF) && b);
      if (r == HALF && b)                  chk("R1 data slot pulse", 32'(wr_pulse), 32'(exp_p));
      else if (r == 1 && !b && !p)         chk("R3 clock slot pulse", 32'(wr_pulse), 32'(exp_p));
      else if (c == 0 && mode == 1)        chk("R4 first zero silent", 32'(wr_pulse), 32'(exp_p));
      else if (!b && p)                    chk("R2 zero after one silent", 32'(wr_pulse), 32'(exp_p));
      else                                 chk("R7 other slots quiet", 32'(wr_pulse), 32'(exp_p));

      if (mode == 0 && c < NBITS) begin
        if ((c % DW) != DW - 1) chk("R5 ready low mid byte", 32'(in_ready), 32'd0);
      end else begin
        chk("R6 ready during underrun", 32'(in_ready), 32'd1);
      end

      if (r == 0 && c >= 1 && (mode == 0 || c <= DW)) begin
        exp_e = (mode == 1) && ((c - 1 == 1) || (c - 1 == 2) || (c - 1 == 4));
        chk("R9 code error at close", 32'(code_err), 32'(exp_e));
      end

      if (out_valid) begin
        chk("R8 byte strobe timing", 32'((r == 0) && (c % DW == 0) && (c > 0)), 32'd1);
        if (mode == 1)        chk("R8 decoded injected byte", 32'(out_data), 32'h8F);
        else if (q < NBYTES)  chk("R8 decoded byte", 32'(out_data), 32'(q));
        else                  chk("R6 underrun decodes zero", 32'(out_data), 32'd0);
        q = q + 1;
      end

      if (mode == 1) inj = ((r == 1) && inj_clk(c)) || ((r == HALF) && inj_dat(c));
      else           inj = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; done = 1'b0;
    mode = 0; mon_on = 1'b0;
    rst_n = 1'b0; enable = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset ready", 32'(in_ready), 32'd1);
    chk("R10 reset pulse", 32'(wr_pulse), 32'd0);
    chk("R10 reset strobe", 32'(out_valid), 32'd0);
    chk("R10 reset error", 32'(code_err), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Loopback sweep of every byte value, streamed back to back.
    in_valid = 1'b1;
    in_data  = 8'd0;
    @(negedge clk);
    enable = 1'b1;
    mon_on = 1'b1;
    for (int v = 1; v < NBYTES; v++) begin
      in_data = DW'(v);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (j < (NBITS + 3 * DW) * CELL + 2) @(negedge clk);
    chk("R8 byte count", 32'(q), 32'(NBYTES + 3));
    enable = 1'b0;
    mon_on = 1'b0;
    @(negedge clk);
    begin
      int hits;
      hits = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (wr_pulse) hits++;
      end
      chk("R7 silent while disabled", 32'(hits), 32'd0);
    end

    // Injected read pulses after a fresh reset, encoder in underrun.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mode = 1;
    enable = 1'b1;
    mon_on = 1'b1;
    while (j < (DW + 1) * CELL + 2) @(negedge clk);
    chk("R8 injected byte count", 32'(q), 32'd1);
    enable = 1'b0;
    mon_on = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule